// File: doc/BRIEF.md
# Bus-Master DMA Register Window

This block is the byte-addressed I/O register window that software uses to program the bus-master DMA channels of a disk controller. Each channel owns an 8-byte slot: four control bytes (command, mode alias, status, timing) followed by a 32-bit descriptor-table pointer. With the default of two channels the window spans 16 bytes, and channel n's slot begins at n*8.

The block decodes each access and rejects any access width that the addressed register does not support. It also applies the per-bit write rules of each register. The status register mixes hardware-held, software-written and write-one-to-clear bits. Byte 1 of every slot is a view of a mode register that is shared by all channels and lives outside this block. A write to that byte is passed on as a read-modify-write through a side port, in which only the two block bits can change. The receiver uses that strobe to resynchronise its mirrored interrupt flags and to re-evaluate the interrupt line. Command and status bits, the timing bytes and the descriptor pointers are brought out to the DMA engine. The engine reports completion and error events back into the status bits.

Reads are combinational in the access cycle. Writes take effect at the next rising clock edge.

Top module: `dmw_window`

## Requirements
- R1: Channel n's control bytes are at offsets n*8+0..3 (0 command, 1 mode alias, 2 status, 3 timing) and its pointer bytes at n*8+4..7; channels never see each other's accesses.
- R2: An access to a control byte with a width other than one byte (acc_size 0=byte, 1=half, 2=word) is ignored on write and reads as all ones at that width (half 0x0000FFFF, word 0xFFFFFFFF).
- R3: The command byte keeps bit 0 (start) and bit 3 (direction), other bits read 0; writing it copies bit 0 into status bit 0 (active); ch_start, ch_dir and ch_active show these bits per channel.
- R4: A byte read of offset 1 returns mode_rd; a byte write there asserts mode_wr_en in the same cycle with mode_wr_data equal to mode_rd except bits 4 and 5, which come from the written data.
- R5: A status write takes bits 5 and 6 from the data, keeps bit 0, clears bit 1 and bit 2 where the data bit is 1; bits 3, 4 and 7 always read 0.
- R6: A one-cycle pulse on ev_err[n] sets status bit 1 and on ev_irq[n] sets status bit 2 of channel n; a set arriving in the same cycle as a clearing write wins.
- R7: A byte write to offset 3 replaces that channel's timing byte completely and the byte appears on ch_timing[n*8+:8].
- R8: The pointer accepts byte accesses at any of its four offsets and word accesses at its first offset; bits 1:0 always read 0; a half-word or misaligned word access is ignored on write and reads as all ones.
- R9: Synchronous reset clears command, status, timing and pointer registers of every channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | CHW+3 | Byte offset inside the window |
| acc_size | input | 2 | 0 byte, 1 half-word, 2 word |
| acc_wdata | input | 32 | Write data, byte writes use bits 7:0 |
| rd_data | output | 32 | Read data, valid in the access cycle |
| mode_rd | input | 8 | Current value of the shared mode register |
| mode_wr_en | output | 1 | Mode register update and resync strobe |
| mode_wr_data | output | 8 | New mode register value |
| ev_err | input | NUM_CH | Per-channel error event from the DMA engine |
| ev_irq | input | NUM_CH | Per-channel interrupt event from the DMA engine |
| ch_start | output | NUM_CH | Command start bit per channel |
| ch_dir | output | NUM_CH | Command direction bit per channel |
| ch_active | output | NUM_CH | Status active bit per channel |
| ch_timing | output | NUM_CH*8 | Timing byte per channel |
| ch_addr | output | NUM_CH*32 | Descriptor pointer per channel |

## Verification
The bench builds the block with its default of two channels, so the channel index is one address bit and both slots can be reached. The slot boundary and cross-channel isolation (writes in one slot observed not to disturb the other) are therefore covered. A non-power-of-two channel count would leave part of the window unmapped, and that case is not reached with these values. The accesses it makes do reach every access width against every region, misaligned pointer words, and the set-over-clear race in status.

// File: rtl/dmw_pkg.sv
package dmw_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    // Order inside a slot is decoded by software, so it is fixed.
    typedef enum logic [1:0] {
        CB_CMD  = 2'd0,
        CB_MODE = 2'd1,
        CB_STAT = 2'd2,
        CB_TIME = 2'd3
    } ctl_byte_e;

    localparam int CMD_START_BIT = 0;
    localparam int CMD_DIR_BIT   = 3;
    localparam logic [7:0] MODE_BLOCK_MASK = 8'h30;

    typedef struct packed {
        logic      in_ptr;
        logic [1:0] bsel;
        logic      ok;
    } dec_t;

    function automatic logic [31:0] ones_for(input acc_size_e s);
        case (s)
            SZ_BYTE: ones_for = 32'h0000_00FF;
            SZ_HALF: ones_for = 32'h0000_FFFF;
            default: ones_for = 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [7:0] status_after_write(input logic [7:0] cur,
                                                      input logic [7:0] wd);
        status_after_write = {1'b0, wd[6:5], 2'b00, cur[2:1] & ~wd[2:1], cur[0]};
    endfunction

    function automatic logic [7:0] cmd_after_write(input logic [7:0] wd);
        cmd_after_write = '0;
        cmd_after_write[CMD_START_BIT] = wd[CMD_START_BIT];
        cmd_after_write[CMD_DIR_BIT]   = wd[CMD_DIR_BIT];
    endfunction

endpackage

// File: rtl/dmw_decode.sv
module dmw_decode
    import dmw_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CHW    = 1
) (
    input  logic [CHW+2:0] addr,
    input  acc_size_e      size,
    output logic [CHW-1:0] ch,
    output dec_t           dec
);
    logic ch_ok;

    always_comb begin
        ch         = addr[CHW+2:3];
        ch_ok      = (int'(ch) < NUM_CH);
        dec.in_ptr = addr[2];
        dec.bsel   = addr[1:0];
        if (dec.in_ptr) begin
            dec.ok = ch_ok && ((size == SZ_BYTE) ||
                               ((size == SZ_WORD) && (dec.bsel == 2'd0)));
        end else begin
            dec.ok = ch_ok && (size == SZ_BYTE);
        end
    end
endmodule

// File: rtl/dmw_channel.sv
module dmw_channel
    import dmw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_cmd,
    input  logic        wr_stat,
    input  logic        wr_time,
    input  logic [3:0]  ptr_be,
    input  logic [31:0] ptr_wd,
    input  logic [7:0]  wd,
    input  logic        ev_err,
    input  logic        ev_irq,
    output logic [7:0]  cmd_q,
    output logic [7:0]  stat_q,
    output logic [7:0]  time_q,
    output logic [31:0] ptr_q
);
    logic [7:0]  stat_nxt;
    logic [31:0] ptr_nxt;
    logic [31:2] ptr_r;

    always_comb begin
        stat_nxt = stat_q;
        if (wr_cmd)  stat_nxt[0] = wd[CMD_START_BIT];
        if (wr_stat) stat_nxt = status_after_write(stat_q, wd);
        if (ev_err)  stat_nxt[1] = 1'b1;
        if (ev_irq)  stat_nxt[2] = 1'b1;
    end

    always_comb begin
        ptr_nxt = {ptr_r, 2'b00};
        for (int b = 0; b < 4; b++) begin
            if (ptr_be[b]) ptr_nxt[b*8 +: 8] = ptr_wd[b*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            stat_q <= '0;
            time_q <= '0;
            ptr_r  <= '0;
        end else begin
            if (wr_cmd)  cmd_q  <= cmd_after_write(wd);
            if (wr_time) time_q <= wd;
            stat_q <= stat_nxt;
            ptr_r  <= ptr_nxt[31:2];
        end
    end

    assign ptr_q = {ptr_r, 2'b00};
endmodule

// File: rtl/dmw_window.sv
module dmw_window
    import dmw_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CHW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic [CHW+2:0]       acc_addr,
    input  logic [1:0]           acc_size,
    input  logic [31:0]          acc_wdata,
    output logic [31:0]          rd_data,
    input  logic [7:0]           mode_rd,
    output logic                 mode_wr_en,
    output logic [7:0]           mode_wr_data,
    input  logic [NUM_CH-1:0]    ev_err,
    input  logic [NUM_CH-1:0]    ev_irq,
    output logic [NUM_CH-1:0]    ch_start,
    output logic [NUM_CH-1:0]    ch_dir,
    output logic [NUM_CH-1:0]    ch_active,
    output logic [NUM_CH*8-1:0]  ch_timing,
    output logic [NUM_CH*32-1:0] ch_addr
);
    acc_size_e      sz;
    dec_t           dec;
    logic [CHW-1:0] ch;
    logic           hon_wr;
    logic [31:0]    ptr_wd;
    logic [3:0]     ptr_be;

    logic [7:0]  cmd_a  [NUM_CH];
    logic [7:0]  stat_a [NUM_CH];
    logic [7:0]  time_a [NUM_CH];
    logic [31:0] ptr_a  [NUM_CH];

    assign sz = acc_size_e'(acc_size);

    dmw_decode #(.NUM_CH(NUM_CH), .CHW(CHW)) u_dec (
        .addr (acc_addr),
        .size (sz),
        .ch   (ch),
        .dec  (dec)
    );

    assign hon_wr = acc_valid && acc_write && dec.ok;

    always_comb begin
        if (sz == SZ_WORD) begin
            ptr_wd = acc_wdata;
            ptr_be = 4'hF;
        end else begin
            ptr_wd = {4{acc_wdata[7:0]}};
            ptr_be = 4'b0001 << dec.bsel;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel_ctl;
        logic sel_ptr;
        assign sel_ctl = hon_wr && (ch == CHW'(c)) && !dec.in_ptr;
        assign sel_ptr = hon_wr && (ch == CHW'(c)) && dec.in_ptr;

        dmw_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .wr_cmd  (sel_ctl && (dec.bsel == CB_CMD)),
            .wr_stat (sel_ctl && (dec.bsel == CB_STAT)),
            .wr_time (sel_ctl && (dec.bsel == CB_TIME)),
            .ptr_be  (sel_ptr ? ptr_be : 4'h0),
            .ptr_wd  (ptr_wd),
            .wd      (acc_wdata[7:0]),
            .ev_err  (ev_err[c]),
            .ev_irq  (ev_irq[c]),
            .cmd_q   (cmd_a[c]),
            .stat_q  (stat_a[c]),
            .time_q  (time_a[c]),
            .ptr_q   (ptr_a[c])
        );

        assign ch_start[c]          = cmd_a[c][CMD_START_BIT];
        assign ch_dir[c]            = cmd_a[c][CMD_DIR_BIT];
        assign ch_active[c]         = stat_a[c][0];
        assign ch_timing[c*8 +: 8]  = time_a[c];
        assign ch_addr[c*32 +: 32]  = ptr_a[c];
    end

    // Shared mode register: read-modify-write toward its owner.
    assign mode_wr_en   = hon_wr && !dec.in_ptr && (dec.bsel == CB_MODE);
    assign mode_wr_data = (mode_rd & ~MODE_BLOCK_MASK) |
                          (acc_wdata[7:0] & MODE_BLOCK_MASK);

    always_comb begin
        rd_data = '0;
        if (acc_valid && !acc_write) begin
            if (!dec.ok) begin
                rd_data = ones_for(sz);
            end else if (dec.in_ptr) begin
                if (sz == SZ_WORD) rd_data = ptr_a[ch];
                else               rd_data = {24'b0, ptr_a[ch][dec.bsel*8 +: 8]};
            end else begin
                case (ctl_byte_e'(dec.bsel))
                    CB_CMD:  rd_data = {24'b0, cmd_a[ch]};
                    CB_MODE: rd_data = {24'b0, mode_rd};
                    CB_STAT: rd_data = {24'b0, stat_a[ch]};
                    default: rd_data = {24'b0, time_a[ch]};
                endcase
            end
        end
    end
endmodule

// File: rtl/dmw_checker.sv
module dmw_checker #(
    parameter int NUM_CH = 2,
    parameter int CHW    = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [CHW+2:0]    acc_addr,
    input logic [1:0]        acc_size,
    input logic [31:0]       acc_wdata,
    input logic [31:0]       rd_data,
    input logic [7:0]        mode_rd,
    input logic              mode_wr_en,
    input logic [7:0]        mode_wr_data,
    input logic [NUM_CH-1:0] ch_start,
    input logic [NUM_CH-1:0] ch_active
);
    logic ctl_acc;
    assign ctl_acc = acc_valid && !acc_addr[2];

    // R2: half-word read of a control byte yields 16 ones
    a_r2_half_read_ones: assert property (@(posedge clk) disable iff (rst)
        (ctl_acc && !acc_write && acc_size == 2'd1) |-> (rd_data == 32'h0000_FFFF));

    // R2: wide writes never reach the mode register
    a_r2_wide_no_mode: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_size != 2'd0) |-> !mode_wr_en);

    // R4: only the block bits differ from the current mode value
    a_r4_mode_keep: assert property (@(posedge clk) disable iff (rst)
        mode_wr_en |-> (((mode_wr_data ^ mode_rd) & 8'hCF) == 8'h00));

    // R4: the strobe comes only from a write to offset 1 of a slot
    a_r4_mode_src: assert property (@(posedge clk) disable iff (rst)
        mode_wr_en |-> (acc_valid && acc_write && acc_addr[2:0] == 3'd1));

    // R3: start bit written as one makes channel 0 active
    a_r3_start_active: assert property (@(posedge clk) disable iff (rst)
        (ctl_acc && acc_write && acc_size == 2'd0 && acc_addr == '0 && acc_wdata[0])
        |=> ch_active[0]);

    // R5: a status write leaves the active bit alone
    a_r5_keep_active: assert property (@(posedge clk) disable iff (rst)
        (ctl_acc && acc_write && acc_size == 2'd0 && acc_addr == (CHW+3)'(2))
        |=> $stable(ch_active[0]));

    // R9: reset clears command and status
    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (ch_active == '0 && ch_start == '0));
endmodule

bind dmw_window dmw_checker #(.NUM_CH(NUM_CH), .CHW(CHW)) u_dmw_chk (
    .clk          (clk),
    .rst          (rst),
    .acc_valid    (acc_valid),
    .acc_write    (acc_write),
    .acc_addr     (acc_addr),
    .acc_size     (acc_size),
    .acc_wdata    (acc_wdata),
    .rd_data      (rd_data),
    .mode_rd      (mode_rd),
    .mode_wr_en   (mode_wr_en),
    .mode_wr_data (mode_wr_data),
    .ch_start     (ch_start),
    .ch_active    (ch_active)
);

// File: tb/test_dmw_window.sv
module test_dmw_window;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [3:0]  acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] rd_data;
    logic [7:0]  mode_rd = 8'h0C;
    logic        mode_wr_en;
    logic [7:0]  mode_wr_data;
    logic [1:0]  ev_err = '0;
    logic [1:0]  ev_irq = '0;
    logic [1:0]  ch_start, ch_dir, ch_active;
    logic [15:0] ch_timing;
    logic [63:0] ch_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [31:0] got_rd;
    logic        got_mwe;
    logic [7:0]  got_mwd;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmw_window #(.NUM_CH(NCH)) i_dmw_window (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .rd_data(rd_data), .mode_rd(mode_rd), .mode_wr_en(mode_wr_en),
        .mode_wr_data(mode_wr_data), .ev_err(ev_err), .ev_irq(ev_irq),
        .ch_start(ch_start), .ch_dir(ch_dir), .ch_active(ch_active),
        .ch_timing(ch_timing), .ch_addr(ch_addr)
    );

    typedef struct packed {
        logic        we;
        logic [3:0]  a;
        logic [1:0]  sz;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 39;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 4'h0, 2'd0, 32'h0,        32'h00,        4'd9}, // R9 cmd after reset
        '{1'b1, 4'h0, 2'd0, 32'h09,       32'h0,         4'd3},
        '{1'b0, 4'h0, 2'd0, 32'h0,        32'h09,        4'd3}, // R3 start+dir kept
        '{1'b0, 4'h2, 2'd0, 32'h0,        32'h01,        4'd3}, // R3 active set
        '{1'b1, 4'h2, 2'd0, 32'hFF,       32'h0,         4'd5},
        '{1'b0, 4'h2, 2'd0, 32'h0,        32'h61,        4'd5}, // R5 mixed bits
        '{1'b1, 4'h3, 2'd0, 32'hA5,       32'h0,         4'd7},
        '{1'b0, 4'h3, 2'd0, 32'h0,        32'hA5,        4'd7}, // R7
        '{1'b0, 4'hB, 2'd0, 32'h0,        32'h00,        4'd1}, // R1 ch1 untouched
        '{1'b1, 4'hB, 2'd0, 32'h3C,       32'h0,         4'd7},
        '{1'b0, 4'hB, 2'd0, 32'h0,        32'h3C,        4'd7}, // R7
        '{1'b0, 4'h3, 2'd0, 32'h0,        32'hA5,        4'd1}, // R1 ch0 kept
        '{1'b1, 4'h4, 2'd2, 32'h12345677, 32'h0,         4'd8},
        '{1'b0, 4'h4, 2'd2, 32'h0,        32'h12345674,  4'd8}, // R8 low bits 0
        '{1'b0, 4'h5, 2'd0, 32'h0,        32'h56,        4'd8}, // R8 byte read
        '{1'b0, 4'h4, 2'd0, 32'h0,        32'h74,        4'd8},
        '{1'b1, 4'h7, 2'd0, 32'hAB,       32'h0,         4'd8},
        '{1'b0, 4'h4, 2'd2, 32'h0,        32'hAB345674,  4'd8}, // R8 byte write
        '{1'b0, 4'h0, 2'd1, 32'h0,        32'h0000FFFF,  4'd2}, // R2 half read
        '{1'b0, 4'h2, 2'd2, 32'h0,        32'hFFFFFFFF,  4'd2}, // R2 word read
        '{1'b1, 4'h3, 2'd1, 32'h0,        32'h0,         4'd2},
        '{1'b0, 4'h3, 2'd0, 32'h0,        32'hA5,        4'd2}, // R2 write ignored
        '{1'b1, 4'h0, 2'd2, 32'h0,        32'h0,         4'd2},
        '{1'b0, 4'h2, 2'd0, 32'h0,        32'h61,        4'd2}, // R2 still active
        '{1'b0, 4'h4, 2'd1, 32'h0,        32'h0000FFFF,  4'd8}, // R8 half read
        '{1'b1, 4'h4, 2'd1, 32'h0,        32'h0,         4'd8},
        '{1'b0, 4'h4, 2'd2, 32'h0,        32'hAB345674,  4'd8}, // R8 half ignored
        '{1'b1, 4'hC, 2'd2, 32'hFFFFFFFF, 32'h0,         4'd8},
        '{1'b0, 4'hC, 2'd2, 32'h0,        32'hFFFFFFFC,  4'd8}, // R8
        '{1'b0, 4'h4, 2'd2, 32'h0,        32'hAB345674,  4'd1}, // R1 isolation
        '{1'b0, 4'h1, 2'd0, 32'h0,        32'h0C,        4'd4}, // R4 mode view
        '{1'b1, 4'h0, 2'd0, 32'h00,       32'h0,         4'd3},
        '{1'b0, 4'h2, 2'd0, 32'h0,        32'h60,        4'd3}, // R3 active cleared
        '{1'b0, 4'h0, 2'd0, 32'h0,        32'h00,        4'd3},
        '{1'b0, 4'h8, 2'd0, 32'h0,        32'h00,        4'd1}, // R1 ch1 cmd
        '{1'b0, 4'h6, 2'd2, 32'h0,        32'hFFFFFFFF,  4'd8}, // R8 misaligned
        '{1'b1, 4'h8, 2'd0, 32'hFF,       32'h0,         4'd3},
        '{1'b0, 4'h8, 2'd0, 32'h0,        32'h09,        4'd3}, // R3 other bits 0
        '{1'b0, 4'hA, 2'd0, 32'h0,        32'h01,        4'd3}  // R3 ch1 active
    };

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic acc(input logic we, input logic [3:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, input logic [1:0] ee, input logic [1:0] ei);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = we; acc_addr = a; acc_size = sz; acc_wdata = wd;
        ev_err = ee; ev_irq = ei;
        #1;
        got_rd = rd_data; got_mwe = mode_wr_en; got_mwd = mode_wr_data;
        @(posedge clk);
        #1;
        acc_valid = 1'b0; acc_write = 1'b0; ev_err = '0; ev_irq = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        do_reset();
        #1;
        // R9 reset state at the ports
        check("R9 active", ch_active, 2'b00);
        check("R9 start", {ch_start, ch_dir}, 4'b0000);
        check("R9 timing", ch_timing, 16'h0000);
        check("R9 pointer", ch_addr, 64'h0);

        for (int i = 0; i < NV; i++) begin
            acc(VEC[i].we, VEC[i].a, VEC[i].sz, VEC[i].wd, 2'b00, 2'b00);
            if (!VEC[i].we) check($sformatf("R%0d vec%0d", VEC[i].req, i), got_rd, VEC[i].exp);
        end

        // R3/R7/R8 port outputs after the table
        check("R3 ch_start", ch_start, 2'b10);
        check("R3 ch_dir", ch_dir, 2'b10);
        check("R7 ch_timing", ch_timing, 16'h3CA5);
        check("R8 ch_addr", ch_addr, 64'hFFFFFFFC_AB345674);

        // R4 mode side port
        mode_rd = 8'hCF;
        acc(1'b1, 4'h1, 2'd0, 32'h10, 2'b00, 2'b00);
        check("R4 mode strobe", got_mwe, 1'b1);
        check("R4 mode data", got_mwd, 8'hDF);
        mode_rd = 8'h00;
        acc(1'b1, 4'h9, 2'd0, 32'hFF, 2'b00, 2'b00);
        check("R4 mode data ch1", got_mwd, 8'h30);
        acc(1'b1, 4'h1, 2'd1, 32'hFFFF, 2'b00, 2'b00);
        check("R2 wide mode write", got_mwe, 1'b0);
        mode_rd = 8'h5A;
        acc(1'b0, 4'h9, 2'd0, 32'h0, 2'b00, 2'b00);
        check("R4 mode read ch1", got_rd, 32'h5A);
        check("R4 no strobe on read", got_mwe, 1'b0);

        // R6 events, R5 clearing
        acc(1'b0, 4'h2, 2'd0, 32'h0, 2'b01, 2'b00);
        acc(1'b0, 4'h2, 2'd0, 32'h0, 2'b00, 2'b00);
        check("R6 err sets bit1", got_rd, 32'h62);
        acc(1'b0, 4'hA, 2'd0, 32'h0, 2'b00, 2'b10);
        acc(1'b0, 4'hA, 2'd0, 32'h0, 2'b00, 2'b00);
        check("R6 irq sets bit2", got_rd, 32'h05);
        acc(1'b1, 4'h2, 2'd0, 32'h02, 2'b00, 2'b00);
        acc(1'b0, 4'h2, 2'd0, 32'h0, 2'b00, 2'b00);
        check("R5 w1c bit1", got_rd, 32'h00);
        acc(1'b1, 4'hA, 2'd0, 32'h04, 2'b00, 2'b10);
        acc(1'b0, 4'hA, 2'd0, 32'h0, 2'b00, 2'b00);
        check("R6 set beats clear", got_rd, 32'h05);
        acc(1'b1, 4'hA, 2'd0, 32'h9C, 2'b00, 2'b00);
        acc(1'b0, 4'hA, 2'd0, 32'h0, 2'b00, 2'b00);
        check("R5 clear bit2, zero bits", got_rd, 32'h01);

        // R9 reset after activity
        do_reset();
        #1;
        check("R9 active after", ch_active, 2'b00);
        check("R9 cmd after", {ch_start, ch_dir}, 4'b0000);
        check("R9 timing after", ch_timing, 16'h0000);
        check("R9 pointer after", ch_addr, 64'h0);
        acc(1'b0, 4'hA, 2'd0, 32'h0, 2'b00, 2'b00);
        check("R9 status after", got_rd, 32'h00);

        done = 1'b1;
        finish_run();
    end
endmodule